// File: doc/BRIEF.md
# Microsequencer Loop Counter Unit

This block is the loop register of a microprogram sequencer, together with the next-address selection that depends on it. The register is loaded from the external data bus, held, or counted down by one. Held, it acts as a saved branch address that the next-address multiplexer can pick. Counted down, it tracks how many more passes a repeated instruction or loop still needs. A zero detector tells the decoder when the count has run out, so that control leaves the loop.

Each cycle the caller supplies the current micro-address, a register operation and an address-source select. The block returns the next micro-address. In loop mode it branches to the bus address while the count is nonzero and falls through to the incremented address once the count is zero.

Top module: `lc_loop_unit`

## Requirements
- R1: An active-high synchronous reset clears the register to zero on the next rising edge.
- R2: Operation code 01 loads `bus_d` into the register at the next rising edge.
- R3: Operation codes 00 and 11 leave the register unchanged.
- R4: Operation code 10 lowers a nonzero register by exactly one at the next rising edge.
- R5: Operation code 10 applied to a zero register leaves it at zero, with no wrap to the all-ones value.
- R6: `cnt_zero` is high in the same cycle exactly when the register value is zero.
- R7: Address select 00 gives `pc_cur + 1` modulo 2^W, select 01 gives `bus_d`, and select 10 gives the register value.
- R8: Address select 11 gives `bus_d` while the register is nonzero and `pc_cur + 1` when it is zero. The test uses the register value before any decrement on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_d | input | W | External data bus: load value and jump or loop target |
| cnt_op | input | 2 | Register operation: 00 hold, 01 load, 10 decrement, 11 hold |
| pc_cur | input | W | Current micro-address |
| nxt_sel | input | 2 | Address source: 00 continue, 01 jump, 10 saved, 11 loop |
| cnt_q | output | W | Register value |
| cnt_zero | output | 1 | High when the register value is zero |
| nxt_addr | output | W | Next micro-address |

## Verification
A corrupted count appears on `cnt_q` and `cnt_zero` in the cycle right after the faulty edge. It also appears on `nxt_addr` in that same cycle whenever select 10 or 11 is active. An off-by-one in the zero test or in the decrement changes how many times the loop body runs, so the bench counts the exact number of taken loop branches before fall-through. A wrap at zero would turn a finished loop into one of 2^W passes, and the first decrement issued while at zero exposes it.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'b00,
    OP_LOAD  = 2'b01,
    OP_DEC   = 2'b10,
    OP_HOLD2 = 2'b11
  } cnt_op_e;

  typedef enum logic [1:0] {
    SEL_CONT  = 2'b00,
    SEL_JUMP  = 2'b01,
    SEL_SAVED = 2'b10,
    SEL_LOOP  = 2'b11
  } nxt_sel_e;
endpackage

// File: rtl/lc_count_reg.sv
module lc_count_reg
  import lc_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  cnt_op_e      op,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q,
  output logic         is_zero
);
  localparam logic [W-1:0] ZERO = '0;

  function automatic logic [W-1:0] sat_dec(input logic [W-1:0] v);
    return (v == ZERO) ? ZERO : v - 1'b1;
  endfunction

  logic [W-1:0] q_nxt;
  logic         dec_evt;

  assign dec_evt = (op == OP_DEC);

  always_comb begin
    unique case (op)
      OP_LOAD: q_nxt = load_val;
      OP_DEC:  q_nxt = sat_dec(q);
      default: q_nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= ZERO;
    else     q <= q_nxt;
  end

  lc_zero_det #(.W(W)) u_zd (.val(q), .zero(is_zero));

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (q == ZERO)); // R1
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD) |=> (q == $past(load_val))); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD || op == OP_HOLD2) |=> $stable(q)); // R3
  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (dec_evt && !is_zero) |=> (q == $past(q) - 1'b1)); // R4
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (dec_evt && is_zero) |=> is_zero); // R5
endmodule

// File: rtl/lc_zero_det.sv
module lc_zero_det #(
  parameter int W = 12
) (
  input  logic [W-1:0] val,
  output logic         zero
);
  assign zero = ~|val;
endmodule

// File: rtl/lc_next_mux.sv
module lc_next_mux
  import lc_pkg::*;
#(
  parameter int W = 12
) (
  input  nxt_sel_e     sel,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] jump_tgt,
  input  logic [W-1:0] saved,
  input  logic         cnt_done,
  output logic [W-1:0] nxt
);
  function automatic logic [W-1:0] incr(input logic [W-1:0] a);
    return a + 1'b1;
  endfunction

  logic [W-1:0] pc_inc;
  logic         loop_taken;

  assign pc_inc     = incr(pc);
  assign loop_taken = (sel == SEL_LOOP) && !cnt_done;

  always_comb begin
    unique case (sel)
      SEL_JUMP:  nxt = jump_tgt;
      SEL_SAVED: nxt = saved;
      SEL_LOOP:  nxt = loop_taken ? jump_tgt : pc_inc;
      default:   nxt = pc_inc;
    endcase
  end

  always_comb begin
    if (sel == SEL_LOOP && cnt_done)
      AST_LOOP_FALLS: assert (nxt == pc + 1'b1); // R8
    if (sel == SEL_SAVED)
      AST_SAVED_PATH: assert (nxt == saved); // R7
  end
endmodule

// File: rtl/lc_loop_unit.sv
module lc_loop_unit
  import lc_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] bus_d,
  input  logic [1:0]   cnt_op,
  input  logic [W-1:0] pc_cur,
  input  logic [1:0]   nxt_sel,
  output logic [W-1:0] cnt_q,
  output logic         cnt_zero,
  output logic [W-1:0] nxt_addr
);
  cnt_op_e  op_e;
  nxt_sel_e sel_e;

  assign op_e  = cnt_op_e'(cnt_op);
  assign sel_e = nxt_sel_e'(nxt_sel);

  lc_count_reg #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .op(op_e), .load_val(bus_d),
    .q(cnt_q), .is_zero(cnt_zero)
  );

  lc_next_mux #(.W(W)) u_mux (
    .sel(sel_e), .pc(pc_cur), .jump_tgt(bus_d), .saved(cnt_q),
    .cnt_done(cnt_zero), .nxt(nxt_addr)
  );

  AST_LOOP_BRANCH: assert property (@(posedge clk) disable iff (rst)
    (nxt_sel == 2'b11 && cnt_q != '0) |-> (nxt_addr == bus_d)); // R8
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    cnt_zero |-> (cnt_q == '0)); // R6
endmodule

// File: tb/test_lc_loop_unit.sv
`timescale 1ns/1ps
module test_lc_loop_unit;
  localparam int W = 12;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] bus_d = '0;
  logic [1:0]   cnt_op = 2'b00;
  logic [W-1:0] pc_cur = '0;
  logic [1:0]   nxt_sel = 2'b00;
  logic [W-1:0] cnt_q;
  logic         cnt_zero;
  logic [W-1:0] nxt_addr;

  int total = 0;
  int bad = 0;
  int ref_cnt = 0;
  string cnt_tag = "R1";
  int cycles = 0;

  always #2.5 clk = ~clk;

  lc_loop_unit #(.W(W)) i_lc_loop_unit (
    .clk(clk), .rst(rst), .bus_d(bus_d), .cnt_op(cnt_op), .pc_cur(pc_cur),
    .nxt_sel(nxt_sel), .cnt_q(cnt_q), .cnt_zero(cnt_zero), .nxt_addr(nxt_addr)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int ref_next(input int sel, input int pc, input int d);
    case (sel)
      1: return d;
      2: return ref_cnt;
      3: return (ref_cnt != 0) ? d : ((pc + 1) & MASK);
      default: return (pc + 1) & MASK;
    endcase
  endfunction

  // drive at negedge, compare, then model the coming edge
  task automatic step(input bit r, input int op, input int d, input int pc, input int sel);
    rst = r; cnt_op = op[1:0]; bus_d = d[W-1:0]; pc_cur = pc[W-1:0]; nxt_sel = sel[1:0];
    #1;
    check(cnt_tag, int'(cnt_q), ref_cnt);
    check("R6", int'(cnt_zero), (ref_cnt == 0) ? 1 : 0);
    check(sel == 3 ? "R8" : "R7", int'(nxt_addr), ref_next(sel, pc, d));
    @(posedge clk);
    if (r) begin ref_cnt = 0; cnt_tag = "R1"; end
    else case (op)
      1: begin ref_cnt = d & MASK; cnt_tag = "R2"; end
      2: begin
        cnt_tag = (ref_cnt == 0) ? "R5" : "R4";
        if (ref_cnt != 0) ref_cnt = ref_cnt - 1;
      end
      default: cnt_tag = "R3";
    endcase
    @(negedge clk);
  endtask

  initial begin
    int taken;
    @(negedge clk);
    step(1, 0, 0, 0, 0);
    // R1 reset state, R7 continue path
    step(0, 0, 'h123, 'h010, 0);
    // R2 load, R7 jump and saved
    step(0, 1, 5, 'h020, 1);
    step(0, 0, 'h0AB, 'h021, 2);
    step(0, 3, 'h0CD, 'h022, 2);
    // R8 loop: count 5 gives 5 taken branches then fall-through
    taken = 0;
    for (int i = 0; i < 8; i++) begin
      if (cnt_q != 0) taken++;
      step(0, 2, 'h040, 'h050, 3);
    end
    check("R8", taken, 5);
    // R5 decrement at zero repeatedly
    step(0, 2, 'h777, 'h060, 3);
    step(0, 2, 'h777, 'h061, 0);
    // R7 increment wraps modulo 2^W; load max value
    step(0, 1, MASK, MASK, 0);
    step(0, 2, 0, 'h100, 2);
    step(0, 2, 0, 'h100, 3);
    step(0, 3, 'h555, 'h101, 1);
    // R8 count 1: exactly one taken branch
    step(0, 1, 1, 'h200, 0);
    step(0, 2, 'h300, 'h201, 3);
    step(0, 2, 'h300, 'h202, 3);
    // R1 reset mid-run
    step(0, 1, 'h0F0, 'h0, 0);
    step(1, 1, 'h0AA, 'h0, 0);
    step(0, 0, 'h0, 'h0, 2);
    for (int i = 0; i < 20; i++)
      step(0, (i * 7) % 4, (i * 389) & MASK, (i * 53) & MASK, (i * 3) % 4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog: got %0d expected %0d", cycles, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule